// File: doc/BRIEF.md
# GPIO Command Port

A command port drives a 64-bit pin output register and a 64-bit output-enable register, and reads back the 64 pin inputs. Each command carries an opcode, a selector, a write/read flag and a transfer kind. A single transfer carries one 32-bit data word. A dual transfer carries two.

Write commands apply one of four operations: replace, toggle, set bits or clear bits. The operation can target one 32-bit half, the full 64-bit register in one cycle, a single pin given by number (with or without a condition), or a half chosen at run time by an index word. Read commands return the output, enable or synchronized input value on the next cycle, as one half or as both halves taken in the same cycle.

Encodings. The selector picks the register. Value 0 is the output low half, 1 the output high half, 4 the enable low half, 5 the enable high half. Values 8 and 9 are the input low and high halves, and can only be read. Opcodes 0..3 mean replace, toggle, set and clear on a mask. Opcodes 5..7 mean toggle, set and clear on one pin. Opcode 4 writes one pin from a value. Opcodes 8..11 are replace, toggle, set and clear on an indexed half.

Top module: `gpio_cmd_port`

## Requirements
- R1: While reset is high, and in the cycle after it, gpio_out, gpio_oe and rd_valid are all zero.
- R2: A single write with opcode 0..3 and selector 0, 1, 4 or 5 changes one half. Opcode 0 replaces it with word0, 1 XORs word0 into it, 2 ORs word0 into it, and 3 clears the bits that are 1 in word0. The other half and the other register do not change.
- R3: A dual write with opcode 0..3 and selector 0 (output) or 4 (enable) applies the same operation to all 64 bits in one cycle, with word0 as bits 31:0 and word1 as bits 63:32. The other register does not change.
- R4: A dual write with opcode 4 and selector 0 or 4 sets the pin numbered by word0 bits 5:0 when word1 is nonzero, and clears it when word1 is zero.
- R5: A single write with opcode 5, 6 or 7 and selector 0 or 4 toggles, sets or clears the pin numbered by word0 bits 5:0, with no condition. Higher bits of word0 are ignored.
- R6: A dual write with opcode 5, 6 or 7 and selector 0 or 4 acts on the pin numbered by word0 bits 5:0 only when word1 bit 0 is 1. When that bit is 0, nothing changes.
- R7: A dual write with opcode 8..11 and selector 0 or 4 applies replace, toggle, set or clear with mask word1. It acts on the low half when word0 is 0 and on the high half when word0 is 1. Any other word0 leaves both registers unchanged.
- R8: Every accepted read raises rd_valid in the next cycle. A single read with opcode 0 and selector 0, 1, 4, 5, 8 or 9 returns that half in rd_word0, with rd_word1 zero. A dual read with opcode 0 and selector 0, 4 or 8 returns the low half in rd_word0 and the high half in rd_word1. Any other read returns zeros.
- R9: gpio_in passes through two synchronizing flops before it can be read. A read accepted in cycle t returns the gpio_in value sampled at the clock edge of cycle t-2, with both halves sampled in the same cycle.
- R10: A write changes the register on the clock edge that accepts it. A read accepted in the very next cycle returns the new value.
- R11: Any other write leaves both registers unchanged. This covers selectors 8 and 9, single opcode 4, single opcodes 8..15, dual writes with a selector other than 0 or 4, and opcodes 12..15. An idle cycle also leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is presented this cycle and is accepted |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_dual | input | 1 | 1 = dual transfer (two words), 0 = single transfer |
| cmd_op | input | 4 | Opcode |
| cmd_sel | input | 4 | Register selector |
| cmd_word0 | input | 32 | First data word |
| cmd_word1 | input | 32 | Second data word (dual transfers only) |
| gpio_in | input | 64 | Raw pin inputs, asynchronous to clk |
| gpio_out | output | 64 | Pin output register |
| gpio_oe | output | 64 | Pin output-enable register |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_word0 | output | 32 | First read word |
| rd_word1 | output | 32 | Second read word |

## Verification
The assertions assume that the command fields are known whenever cmd_valid is high. They also assume that reset is held long enough to flush the input synchronizer. The stimulus drives every command field to a defined value on every cycle, with random values when idle. It draws selectors only from the defined codes plus one unused code (2). It keeps random pin numbers and index words small enough to hit both valid and invalid index values.

// File: rtl/gpio_cmd_pkg.sv
package gpio_cmd_pkg;

  typedef enum logic [1:0] {
    BOP_PUT = 2'd0,
    BOP_XOR = 2'd1,
    BOP_SET = 2'd2,
    BOP_CLR = 2'd3
  } bank_op_e;

  localparam int SEL_OUT_LO = 0;
  localparam int SEL_OUT_HI = 1;
  localparam int SEL_OE_LO  = 4;
  localparam int SEL_OE_HI  = 5;
  localparam int SEL_IN_LO  = 8;
  localparam int SEL_IN_HI  = 9;

  localparam int OPC_PIN_PUT = 4;
  localparam int OPC_PIN_XOR = 5;
  localparam int OPC_PIN_CLR = 7;
  localparam int OPC_IDX_PUT = 8;
  localparam int OPC_IDX_CLR = 11;

  localparam int BANK_OUT = 0;
  localparam int BANK_OE  = 1;
  localparam int NUM_BANKS = 2;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 64,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else     chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_reg.sv
module gpio_bank_reg
  import gpio_cmd_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  bank_op_e     op,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  logic [W-1:0] eff;
  logic [W-1:0] nxt;

  assign eff = data & mask;

  always_comb begin
    unique case (op)
      BOP_PUT: nxt = (q & ~mask) | eff;
      BOP_XOR: nxt = q ^ eff;
      BOP_SET: nxt = q | eff;
      BOP_CLR: nxt = q & ~eff;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/gpio_cmd_decode.sv
module gpio_cmd_decode
  import gpio_cmd_pkg::*;
#(
  parameter int HALF_W = 32,
  parameter int OP_W   = 4,
  parameter int SEL_W  = 4,
  localparam int FULL_W = 2 * HALF_W,
  localparam int PIN_W  = $clog2(FULL_W)
) (
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic                 cmd_dual,
  input  logic [OP_W-1:0]      cmd_op,
  input  logic [SEL_W-1:0]     cmd_sel,
  input  logic [HALF_W-1:0]    cmd_word0,
  input  logic [HALF_W-1:0]    cmd_word1,
  output logic [NUM_BANKS-1:0] upd_en,
  output bank_op_e             upd_op,
  output logic [FULL_W-1:0]    upd_mask,
  output logic [FULL_W-1:0]    upd_data
);
  localparam logic [HALF_W-1:0] ONES  = '1;
  localparam logic [HALF_W-1:0] ZEROS = '0;

  logic              sel_half;
  logic              sel_pin_ok;
  logic              to_oe;
  logic              act;
  logic [PIN_W-1:0]  pin;
  logic [FULL_W-1:0] pin_hot;
  logic              idx_ok;

  assign sel_half   = (cmd_sel == SEL_W'(SEL_OUT_LO)) || (cmd_sel == SEL_W'(SEL_OUT_HI)) ||
                      (cmd_sel == SEL_W'(SEL_OE_LO))  || (cmd_sel == SEL_W'(SEL_OE_HI));
  assign sel_pin_ok = (cmd_sel == SEL_W'(SEL_OUT_LO)) || (cmd_sel == SEL_W'(SEL_OE_LO));
  assign to_oe      = (cmd_sel == SEL_W'(SEL_OE_LO))  || (cmd_sel == SEL_W'(SEL_OE_HI));
  assign pin        = cmd_word0[PIN_W-1:0];
  assign pin_hot    = {{(FULL_W-1){1'b0}}, 1'b1} << pin;
  assign idx_ok     = (cmd_word0 == HALF_W'(0)) || (cmd_word0 == HALF_W'(1));

  always_comb begin
    act      = 1'b0;
    upd_op   = bank_op_e'(cmd_op[1:0]);
    upd_mask = '0;
    upd_data = '0;
    if (cmd_valid && cmd_write) begin
      if (!cmd_dual) begin
        if (cmd_op < OP_W'(OPC_PIN_PUT) && sel_half) begin
          act      = 1'b1;
          upd_mask = cmd_sel[0] ? {ONES, ZEROS} : {ZEROS, ONES};
          upd_data = cmd_sel[0] ? {cmd_word0, ZEROS} : {ZEROS, cmd_word0};
        end else if (cmd_op >= OP_W'(OPC_PIN_XOR) && cmd_op <= OP_W'(OPC_PIN_CLR) && sel_pin_ok) begin
          act      = 1'b1;
          upd_mask = pin_hot;
          upd_data = pin_hot;
        end
      end else if (sel_pin_ok) begin
        if (cmd_op < OP_W'(OPC_PIN_PUT)) begin
          act      = 1'b1;
          upd_mask = '1;
          upd_data = {cmd_word1, cmd_word0};
        end else if (cmd_op == OP_W'(OPC_PIN_PUT)) begin
          act      = 1'b1;
          upd_op   = (|cmd_word1) ? BOP_SET : BOP_CLR;
          upd_mask = pin_hot;
          upd_data = pin_hot;
        end else if (cmd_op <= OP_W'(OPC_PIN_CLR)) begin
          act      = cmd_word1[0];
          upd_mask = pin_hot;
          upd_data = pin_hot;
        end else if (cmd_op >= OP_W'(OPC_IDX_PUT) && cmd_op <= OP_W'(OPC_IDX_CLR)) begin
          act      = idx_ok;
          upd_mask = cmd_word0[0] ? {ONES, ZEROS} : {ZEROS, ONES};
          upd_data = cmd_word0[0] ? {cmd_word1, ZEROS} : {ZEROS, cmd_word1};
        end
      end
    end
  end

  always_comb begin
    upd_en           = '0;
    upd_en[BANK_OUT] = act && !to_oe;
    upd_en[BANK_OE]  = act && to_oe;
  end
endmodule

// File: rtl/gpio_cmd_port.sv
module gpio_cmd_port
  import gpio_cmd_pkg::*;
#(
  parameter int HALF_W      = 32,
  parameter int OP_W        = 4,
  parameter int SEL_W       = 4,
  parameter int SYNC_STAGES = 2,
  localparam int FULL_W = 2 * HALF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  logic              cmd_dual,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic [HALF_W-1:0] cmd_word0,
  input  logic [HALF_W-1:0] cmd_word1,
  input  logic [FULL_W-1:0] gpio_in,
  output logic [FULL_W-1:0] gpio_out,
  output logic [FULL_W-1:0] gpio_oe,
  output logic              rd_valid,
  output logic [HALF_W-1:0] rd_word0,
  output logic [HALF_W-1:0] rd_word1
);
  logic [NUM_BANKS-1:0] upd_en;
  bank_op_e             upd_op;
  logic [FULL_W-1:0]    upd_mask;
  logic [FULL_W-1:0]    upd_data;
  logic [FULL_W-1:0]    bank_q [NUM_BANKS];
  logic [FULL_W-1:0]    in_sync;

  gpio_cmd_decode #(.HALF_W(HALF_W), .OP_W(OP_W), .SEL_W(SEL_W)) u_dec (
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_dual  (cmd_dual),
    .cmd_op    (cmd_op),
    .cmd_sel   (cmd_sel),
    .cmd_word0 (cmd_word0),
    .cmd_word1 (cmd_word1),
    .upd_en    (upd_en),
    .upd_op    (upd_op),
    .upd_mask  (upd_mask),
    .upd_data  (upd_data)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    gpio_bank_reg #(.W(FULL_W)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .en   (upd_en[b]),
      .op   (upd_op),
      .mask (upd_mask),
      .data (upd_data),
      .q    (bank_q[b])
    );
  end

  assign gpio_out = bank_q[BANK_OUT];
  assign gpio_oe  = bank_q[BANK_OE];

  gpio_in_sync #(.W(FULL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (gpio_in),
    .q   (in_sync)
  );

  logic [FULL_W-1:0] rd_src;
  logic              rd_src_ok;
  logic              rd_pair_ok;
  logic [HALF_W-1:0] rd_n0;
  logic [HALF_W-1:0] rd_n1;

  always_comb begin
    rd_src    = '0;
    rd_src_ok = 1'b1;
    unique case (cmd_sel)
      SEL_W'(SEL_OUT_LO), SEL_W'(SEL_OUT_HI): rd_src = bank_q[BANK_OUT];
      SEL_W'(SEL_OE_LO),  SEL_W'(SEL_OE_HI):  rd_src = bank_q[BANK_OE];
      SEL_W'(SEL_IN_LO),  SEL_W'(SEL_IN_HI):  rd_src = in_sync;
      default:                                rd_src_ok = 1'b0;
    endcase
    rd_pair_ok = rd_src_ok && !cmd_sel[0];
    rd_n0 = '0;
    rd_n1 = '0;
    if (cmd_op == OP_W'(0)) begin
      if (!cmd_dual && rd_src_ok) begin
        rd_n0 = cmd_sel[0] ? rd_src[FULL_W-1:HALF_W] : rd_src[HALF_W-1:0];
      end else if (cmd_dual && rd_pair_ok) begin
        rd_n0 = rd_src[HALF_W-1:0];
        rd_n1 = rd_src[FULL_W-1:HALF_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_word0 <= '0;
      rd_word1 <= '0;
    end else begin
      rd_valid <= cmd_valid && !cmd_write;
      if (cmd_valid && !cmd_write) begin
        rd_word0 <= rd_n0;
        rd_word1 <= rd_n1;
      end
    end
  end
endmodule

// File: rtl/gpio_cmd_port_chk.sv
module gpio_cmd_port_chk #(
  parameter int HALF_W = 32,
  parameter int OP_W   = 4,
  parameter int SEL_W  = 4,
  localparam int FULL_W = 2 * HALF_W,
  localparam int PIN_W  = $clog2(FULL_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_write,
  input logic              cmd_dual,
  input logic [OP_W-1:0]   cmd_op,
  input logic [SEL_W-1:0]  cmd_sel,
  input logic [HALF_W-1:0] cmd_word0,
  input logic [HALF_W-1:0] cmd_word1,
  input logic [FULL_W-1:0] gpio_out,
  input logic [FULL_W-1:0] gpio_oe,
  input logic              rd_valid
);
  logic wr;
  assign wr = cmd_valid && cmd_write;

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (gpio_out == '0 && gpio_oe == '0 && !rd_valid));

  assert_out_full_spares_oe_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd_dual && cmd_op < OP_W'(4) && cmd_sel == SEL_W'(0)) |=> $stable(gpio_oe));

  assert_pin_set_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && !cmd_dual && cmd_op == OP_W'(6) && cmd_sel == SEL_W'(0))
    |=> gpio_out[$past(cmd_word0[PIN_W-1:0])]);

  assert_pin_clr_R5: assert property (@(posedge clk) disable iff (rst)
    (wr && !cmd_dual && cmd_op == OP_W'(7) && cmd_sel == SEL_W'(4))
    |=> !gpio_oe[$past(cmd_word0[PIN_W-1:0])]);

  assert_cond_skip_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd_dual && cmd_op >= OP_W'(5) && cmd_op <= OP_W'(7) && !cmd_word1[0])
    |=> ($stable(gpio_out) && $stable(gpio_oe)));

  assert_bad_index_R7: assert property (@(posedge clk) disable iff (rst)
    (wr && cmd_dual && cmd_op >= OP_W'(8) && cmd_op <= OP_W'(11) && cmd_word0 > HALF_W'(1))
    |=> ($stable(gpio_out) && $stable(gpio_oe)));

  assert_read_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_write) |=> rd_valid);

  assert_no_read_R8: assert property (@(posedge clk) disable iff (rst)
    !(cmd_valid && !cmd_write) |=> !rd_valid);

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(gpio_out) && $stable(gpio_oe)));
endmodule

bind gpio_cmd_port gpio_cmd_port_chk #(.HALF_W(HALF_W), .OP_W(OP_W), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_write (cmd_write),
  .cmd_dual  (cmd_dual),
  .cmd_op    (cmd_op),
  .cmd_sel   (cmd_sel),
  .cmd_word0 (cmd_word0),
  .cmd_word1 (cmd_word1),
  .gpio_out  (gpio_out),
  .gpio_oe   (gpio_oe),
  .rd_valid  (rd_valid)
);

// File: tb/gpio_cmd_port_test.sv
module gpio_cmd_port_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, cmd_dual = 1'b0;
  logic [3:0]  cmd_op = '0, cmd_sel = '0;
  logic [31:0] cmd_word0 = '0, cmd_word1 = '0;
  logic [63:0] gpio_in = '0;
  logic [63:0] gpio_out, gpio_oe;
  logic        rd_valid;
  logic [31:0] rd_word0, rd_word1;

  gpio_cmd_port uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_dual(cmd_dual), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .cmd_word0(cmd_word0), .cmd_word1(cmd_word1), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .gpio_oe(gpio_oe), .rd_valid(rd_valid),
    .rd_word0(rd_word0), .rd_word1(rd_word1)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    started  = 0;
  bit    finished = 0;
  string drv_req  = "R1";
  string cmp_req  = "R1";

  logic [63:0] m_out, m_oe, m_s1, m_s2;
  logic        exp_rv;
  logic [31:0] exp_r0, exp_r1;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] apply_op(input int op, input logic [63:0] cur, input logic [63:0] m,
                                           input logic [63:0] v);
    case (op)
      0: return (cur & ~m) | (v & m);
      1: return cur ^ (v & m);
      2: return cur | (v & m);
      default: return cur & ~(v & m);
    endcase
  endfunction

  // Reference model, evaluated on the sampled command at each rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_out = '0; m_oe = '0; m_s1 = '0; m_s2 = '0; exp_rv = 0; exp_r0 = '0; exp_r1 = '0;
    end else begin
      int op, sel, pin;
      logic [63:0] reg_v, src, hm;
      bit oe_t, ok_src;
      op = int'(cmd_op); sel = int'(cmd_sel); pin = int'(cmd_word0 % 64);
      exp_rv = cmd_valid && !cmd_write;
      if (exp_rv) begin
        ok_src = 1;
        if (sel == 0 || sel == 1) src = m_out;
        else if (sel == 4 || sel == 5) src = m_oe;
        else if (sel == 8 || sel == 9) src = m_s2;
        else begin src = '0; ok_src = 0; end
        exp_r0 = '0; exp_r1 = '0;
        if (op == 0 && ok_src && !cmd_dual) exp_r0 = (sel % 2 == 1) ? src[63:32] : src[31:0];
        if (op == 0 && ok_src && cmd_dual && sel % 2 == 0) begin exp_r0 = src[31:0]; exp_r1 = src[63:32]; end
      end
      if (cmd_valid && cmd_write) begin
        oe_t = (sel == 4 || sel == 5);
        reg_v = oe_t ? m_oe : m_out;
        if (!cmd_dual) begin
          if (op < 4 && (sel == 0 || sel == 1 || sel == 4 || sel == 5)) begin
            hm = (sel % 2 == 1) ? 64'hFFFFFFFF_00000000 : 64'h00000000_FFFFFFFF;
            reg_v = apply_op(op, reg_v, hm, {cmd_word0, cmd_word0});
          end else if (op >= 5 && op <= 7 && (sel == 0 || sel == 4)) begin
            if (op == 5) reg_v[pin] = ~reg_v[pin];
            else reg_v[pin] = (op == 6);
          end
        end else if (sel == 0 || sel == 4) begin
          if (op < 4) reg_v = apply_op(op, reg_v, '1, {cmd_word1, cmd_word0});
          else if (op == 4) reg_v[pin] = (cmd_word1 != 0);
          else if (op <= 7) begin
            if (cmd_word1[0]) begin
              if (op == 5) reg_v[pin] = ~reg_v[pin];
              else reg_v[pin] = (op == 6);
            end
          end else if (op <= 11 && cmd_word0 < 2) begin
            hm = (cmd_word0 == 1) ? 64'hFFFFFFFF_00000000 : 64'h00000000_FFFFFFFF;
            reg_v = apply_op(op - 8, reg_v, hm, {cmd_word1, cmd_word1});
          end
        end
        if (oe_t) m_oe = reg_v; else m_out = reg_v;
      end
      m_s2 = m_s1; m_s1 = gpio_in;
    end
    cmp_req = drv_req;
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      check(gpio_out === m_out, cmp_req, gpio_out, m_out);
      check(gpio_oe === m_oe, cmp_req, gpio_oe, m_oe);
      check(rd_valid === exp_rv, cmp_req, {63'd0, rd_valid}, {63'd0, exp_rv});
      if (exp_rv) check({rd_word1, rd_word0} === {exp_r1, exp_r0}, cmp_req,
                        {rd_word1, rd_word0}, {exp_r1, exp_r0});
    end
  end

  task automatic send(input string req, input bit wr, input bit dual, input int op, input int sel,
                      input logic [31:0] w0, input logic [31:0] w1);
    drv_req = req;
    cmd_valid = 1; cmd_write = wr; cmd_dual = dual;
    cmd_op = 4'(op); cmd_sel = 4'(sel); cmd_word0 = w0; cmd_word1 = w1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    cmd_valid = 0; cmd_write = $urandom; cmd_dual = $urandom;
    cmd_op = 4'($urandom); cmd_sel = 4'($urandom); cmd_word0 = $urandom; cmd_word1 = $urandom;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gpio_out === 64'd0 && gpio_oe === 64'd0, "R1", gpio_out | gpio_oe, 64'd0);
    check(rd_valid === 1'b0, "R1", {63'd0, rd_valid}, 64'd0);
    rst = 0;
    @(negedge clk);
    check(gpio_out === 64'd0, "R1", gpio_out, 64'd0);

    // R2 half operations
    send("R2", 1, 0, 0, 0, 32'hA5A5_0F0F, 0);
    send("R2", 1, 0, 0, 1, 32'h1234_5678, 0);
    send("R2", 1, 0, 1, 1, 32'hFFFF_0000, 0);
    send("R2", 1, 0, 2, 4, 32'h0000_00F0, 0);
    send("R2", 1, 0, 3, 0, 32'h0000_000F, 0);
    idle(1);
    check(gpio_out === 64'hEDCB5678_A5A50F00, "R2", gpio_out, 64'hEDCB5678_A5A50F00);
    send("R2", 1, 0, 2, 5, 32'h8000_0001, 0);
    send("R2", 1, 0, 3, 4, 32'h0000_0010, 0);

    // R3 full 64-bit operations
    send("R3", 1, 1, 0, 0, 32'h0000_FFFF, 32'hDEAD_BEEF);
    idle(1);
    check(gpio_out === 64'hDEADBEEF_0000FFFF, "R3", gpio_out, 64'hDEADBEEF_0000FFFF);
    send("R3", 1, 1, 1, 0, 32'hFFFF_FFFF, 32'h0000_0001);
    send("R3", 1, 1, 2, 4, 32'h0101_0101, 32'h1000_0000);
    send("R3", 1, 1, 3, 4, 32'h0000_0001, 32'h8000_0001);

    // R4 single pin write from value
    send("R4", 1, 1, 4, 0, 40, 7);
    send("R4", 1, 1, 4, 0, 0, 0);
    send("R4", 1, 1, 4, 4, 63, 32'h8000_0000);

    // R5 unconditional pin ops, pin number taken modulo 64
    send("R5", 1, 0, 5, 0, 63, 0);
    send("R5", 1, 0, 6, 0, 70, 0);
    send("R5", 1, 0, 7, 4, 63, 0);
    send("R5", 1, 0, 6, 4, 32'hFFFF_FFC2, 0);
    idle(1);
    check(gpio_oe[2] === 1'b1, "R5", {63'd0, gpio_oe[2]}, 64'd1);

    // R6 conditional pin ops
    send("R6", 1, 1, 6, 0, 12, 32'hFFFF_FFFE);
    send("R6", 1, 1, 6, 0, 12, 1);
    send("R6", 1, 1, 5, 4, 33, 0);
    send("R6", 1, 1, 5, 4, 33, 3);
    send("R6", 1, 1, 7, 0, 12, 1);

    // R7 indexed half ops
    send("R7", 1, 1, 8, 0, 0, 32'h1111_2222);
    send("R7", 1, 1, 8, 0, 1, 32'h3333_4444);
    send("R7", 1, 1, 9, 4, 1, 32'hF0F0_F0F0);
    send("R7", 1, 1, 10, 4, 0, 32'h0000_FF00);
    send("R7", 1, 1, 11, 0, 1, 32'h0000_4400);
    send("R7", 1, 1, 8, 0, 2, 32'hFFFF_FFFF);
    send("R7", 1, 1, 10, 4, 32'h8000_0000, 32'hFFFF_FFFF);

    // R8 reads
    send("R8", 0, 0, 0, 0, 0, 0);
    send("R8", 0, 0, 0, 1, 0, 0);
    send("R8", 0, 1, 0, 4, 0, 0);
    send("R8", 0, 0, 0, 5, 0, 0);
    send("R8", 0, 1, 0, 1, 0, 0);
    send("R8", 0, 0, 3, 0, 0, 0);
    idle(2);

    // R9 input synchronizer latency
    gpio_in = 64'hCAFE_0001_BEEF_0002;
    send("R9", 0, 1, 0, 8, 0, 0);
    send("R9", 0, 1, 0, 8, 0, 0);
    send("R9", 0, 0, 0, 9, 0, 0);
    send("R9", 0, 0, 0, 8, 0, 0);
    idle(1);

    // R10 write then immediate read-back
    send("R10", 1, 0, 6, 0, 3, 0);
    send("R10", 0, 0, 0, 0, 0, 0);
    send("R10", 1, 1, 0, 4, 32'h7777_7777, 32'h5555_5555);
    send("R10", 0, 1, 0, 4, 0, 0);
    idle(1);

    // R11 unsupported writes have no effect
    send("R11", 1, 0, 4, 0, 5, 1);
    send("R11", 1, 1, 0, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send("R11", 1, 0, 0, 8, 32'hFFFF_FFFF, 0);
    send("R11", 1, 0, 9, 0, 0, 32'hFFFF_FFFF);
    send("R11", 1, 1, 12, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    send("R11", 1, 0, 2, 2, 32'hFFFF_FFFF, 0);
    idle(3);

    // Mixed random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      int sels[7] = '{0, 1, 4, 5, 8, 9, 2};
      int op, sel;
      logic [31:0] w0, w1;
      if (i % 5 == 0) gpio_in = {$urandom, $urandom};
      op  = $urandom % 13;
      sel = sels[$urandom % 7];
      w0  = (op >= 8) ? 32'($urandom % 3) : ((op >= 4) ? 32'($urandom % 128) : $urandom);
      w1  = $urandom;
      if ($urandom % 6 == 0) idle(1);
      else send("R2/R3/R6/R7/R8", $urandom % 3 != 0, $urandom, op, sel, w0, w1);
    end
    idle(4);
    finish_run();
  end
endmodule